// File: doc/BRIEF.md
# Lookup-Table Distributed RAM, 16x2, Single or Dual Port

This block models a small distributed memory assembled from lookup tables, where every table is treated as a 16-word by 1-bit storage cell. One group of cells (one "slice", two cells wide by default) forms a 16x2 single-port memory. In this memory, the write address also selects the word that is read back.

With the mode parameter set to dual port, a second group of cells is added beside the first. Each write goes into both groups on the same clock edge, with the same address and data, so the second group always holds a mirrored copy. That second copy answers its own read address. The result is one read-write port plus one independent read-only port. Writes happen on the rising clock edge. Both reads are purely combinational from their addresses.

A synchronous active-high reset blocks writes while it is held. It does not clear the stored words, because the contents are undefined at power-up anyway.

Top module: `lutram_dp`

## Requirements
- R1: On a rising clock edge with `we` high and `rst` low, the word `wdata` is stored at `waddr`. From then on, `rw_rdata` shows that word whenever `waddr` selects it.
- R2: On an edge with `we` low, no stored word changes. Any value on `wdata` on that edge has no effect.
- R3: While `rst` is high, `we` is ignored and no stored word changes. The reset does not clear the memory.
- R4: In dual-port mode, `ro_rdata` shows the word stored at `ro_addr`, whatever the value of `waddr`.
- R5: In dual-port mode, every write updates both copies. Whenever `ro_addr` equals `waddr`, `ro_rdata` equals `rw_rdata`.
- R6: In dual-port mode, when `ro_addr` equals `waddr` on a write cycle, `ro_rdata` shows the old word before the edge and the new word after it.
- R7: In single-port mode (`MODE` = `MODE_SP`), `ro_rdata` is held at all zeros and `ro_addr` has no effect.
- R8: Both read ports are asynchronous. A change of `waddr` or `ro_addr` changes the read data within the same cycle, with no clock edge needed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Write clock, rising edge |
| rst | input | 1 | Synchronous active-high reset; blocks writes |
| we | input | 1 | Write enable |
| waddr | input | AW (4) | Write address, also the read-write port's read address |
| wdata | input | W (2) | Write data |
| rw_rdata | output | W (2) | Asynchronous read of the word at `waddr` |
| ro_addr | input | AW (4) | Read-only port address |
| ro_rdata | output | W (2) | Asynchronous read of the word at `ro_addr` (zero in single-port mode) |

## Verification
The assertions assume that every input is a settled 0 or 1 at each rising edge. They also assume `rst` is held high from time zero until the first edge, so that no property looks back at a cycle before reset. The assertions compare the two copies directly, so they also take for granted that both copies start out equal. The stimulus meets these assumptions. It changes inputs only on falling edges and starts with reset asserted. It writes all sixteen words before any read is compared, and after that it mixes random writes, idle cycles and reset pulses with directed address collisions.

// File: rtl/lutram_pkg.sv
package lutram_pkg;

  typedef enum logic {
    MODE_SP = 1'b0,
    MODE_DP = 1'b1
  } mode_e;

  localparam int unsigned LUT_INPUTS      = 4;
  localparam int unsigned CELLS_PER_SLICE = 2;

endpackage

// File: rtl/lutram_cell.sv
module lutram_cell #(
  parameter int unsigned AW = lutram_pkg::LUT_INPUTS
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic          wbit,
  input  logic [AW-1:0] raddr,
  output logic          rbit
);

  localparam int unsigned DEPTH = 1 << AW;

  logic [DEPTH-1:0] store;

  always_ff @(posedge clk) begin
    if (we) begin
      store[waddr] <= wbit;
    end
  end

  assign rbit = store[raddr];

endmodule

// File: rtl/lutram_slice.sv
module lutram_slice #(
  parameter int unsigned AW = lutram_pkg::LUT_INPUTS,
  parameter int unsigned W  = lutram_pkg::CELLS_PER_SLICE
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);

  for (genvar b = 0; b < W; b++) begin : g_bit
    lutram_cell #(.AW(AW)) i_cell (
      .clk   (clk),
      .we    (we),
      .waddr (waddr),
      .wbit  (wdata[b]),
      .raddr (raddr),
      .rbit  (rdata[b])
    );
  end

endmodule

// File: rtl/lutram_dp.sv
module lutram_dp #(
  parameter int unsigned      AW   = lutram_pkg::LUT_INPUTS,
  parameter int unsigned      W    = lutram_pkg::CELLS_PER_SLICE,
  parameter lutram_pkg::mode_e MODE = lutram_pkg::MODE_DP
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  output logic [W-1:0]  rw_rdata,
  input  logic [AW-1:0] ro_addr,
  output logic [W-1:0]  ro_rdata
);

  logic wr_go;
  assign wr_go = we & ~rst;

  // Primary copy: write port and read-write read share one address.
  lutram_slice #(.AW(AW), .W(W)) i_rw_slice (
    .clk   (clk),
    .we    (wr_go),
    .waddr (waddr),
    .wdata (wdata),
    .raddr (waddr),
    .rdata (rw_rdata)
  );

  if (MODE == lutram_pkg::MODE_DP) begin : g_dual
    // Mirror copy: same write stream, separate read address.
    lutram_slice #(.AW(AW), .W(W)) i_ro_slice (
      .clk   (clk),
      .we    (wr_go),
      .waddr (waddr),
      .wdata (wdata),
      .raddr (ro_addr),
      .rdata (ro_rdata)
    );
  end else begin : g_single
    logic unused_ro_addr;
    assign unused_ro_addr = ^ro_addr;
    assign ro_rdata       = '0;
  end

endmodule

// File: rtl/lutram_dp_chk.sv
module lutram_dp_chk #(
  parameter int unsigned      AW   = 4,
  parameter int unsigned      W    = 2,
  parameter lutram_pkg::mode_e MODE = lutram_pkg::MODE_DP
) (
  input logic          clk,
  input logic          rst,
  input logic          we,
  input logic [AW-1:0] waddr,
  input logic [W-1:0]  wdata,
  input logic [W-1:0]  rw_rdata,
  input logic [AW-1:0] ro_addr,
  input logic [W-1:0]  ro_rdata
);

  // R1: a committed write is visible when the same address is read next cycle
  a_r1_write_visible: assert property (@(posedge clk) disable iff (rst)
    ($past(we && !rst) && waddr == $past(waddr)) |-> rw_rdata == $past(wdata));

  // R2: no write enable, the addressed word keeps its value
  a_r2_idle_hold: assert property (@(posedge clk) disable iff (rst)
    ($past(!we) && waddr == $past(waddr)) |-> rw_rdata == $past(rw_rdata));

  // R3: a cycle spent in reset changes nothing
  a_r3_reset_hold: assert property (@(posedge clk) disable iff (rst)
    ($past(rst) && waddr == $past(waddr)) |-> rw_rdata == $past(rw_rdata));

  if (MODE == lutram_pkg::MODE_DP) begin : g_dp
    // R5: both copies agree when they read the same address
    a_r5_mirror: assert property (@(posedge clk) disable iff (rst)
      (ro_addr == waddr) |-> ro_rdata == rw_rdata);

    // R6: read-only port reflects a write to its address after the edge
    a_r6_collision_new: assert property (@(posedge clk) disable iff (rst)
      ($past(we && !rst) && ro_addr == $past(waddr)) |-> ro_rdata == $past(wdata));
  end else begin : g_sp
    // R7: unused read-only output stays zero
    a_r7_sp_zero: assert property (@(posedge clk) disable iff (rst)
      ro_rdata == '0);
  end

endmodule

bind lutram_dp lutram_dp_chk #(.AW(AW), .W(W), .MODE(MODE)) i_chk (
  .clk      (clk),
  .rst      (rst),
  .we       (we),
  .waddr    (waddr),
  .wdata    (wdata),
  .rw_rdata (rw_rdata),
  .ro_addr  (ro_addr),
  .ro_rdata (ro_rdata)
);

// File: tb/test_lutram_dp.sv
module test_lutram_dp;
  localparam int CLK_P = 10;
  localparam int AW    = 4;
  localparam int W     = 2;
  localparam int DEPTH = 1 << AW;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          we  = 1'b0;
  logic [AW-1:0] waddr = '0;
  logic [W-1:0]  wdata = '0;
  logic [AW-1:0] ro_addr = '0;
  logic [W-1:0]  rw_rdata, ro_rdata;
  logic [W-1:0]  sp_rw_rdata, sp_ro_rdata;

  logic [W-1:0]  model [DEPTH];
  int checks = 0;
  int fails  = 0;

  always #(CLK_P/2) clk = ~clk;

  lutram_dp #(.AW(AW), .W(W), .MODE(lutram_pkg::MODE_DP)) i_lutram_dp (
    .clk(clk), .rst(rst), .we(we), .waddr(waddr), .wdata(wdata),
    .rw_rdata(rw_rdata), .ro_addr(ro_addr), .ro_rdata(ro_rdata));

  lutram_dp #(.AW(AW), .W(W), .MODE(lutram_pkg::MODE_SP)) i_lutram_dp_sp (
    .clk(clk), .rst(rst), .we(we), .waddr(waddr), .wdata(wdata),
    .rw_rdata(sp_rw_rdata), .ro_addr(ro_addr), .ro_rdata(sp_ro_rdata));

  function automatic logic [W-1:0] exp_word(input logic [AW-1:0] a);
    return model[a];
  endfunction

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  // Drive on the falling edge, let the combinational reads settle.
  task automatic drive(input logic w, input logic [AW-1:0] a, input logic [W-1:0] d,
                       input logic [AW-1:0] ra);
    @(negedge clk);
    we = w; waddr = a; wdata = d; ro_addr = ra;
    #1;
  endtask

  // Cross the rising edge; record what the requirements say was stored.
  task automatic tick();
    @(posedge clk);
    if (we && !rst) model[waddr] = wdata;
    #1;
  endtask

  initial begin
    #(CLK_P * 100000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    // Reset state: single-port read-only output is zero (R7)
    repeat (3) @(posedge clk);
    #1;
    check("R7 reset", sp_ro_rdata, '0);
    @(negedge clk); rst = 1'b0;

    // Fill every word (R1)
    for (int a = 0; a < DEPTH; a++) begin
      drive(1'b1, AW'(a), W'(a ^ (a >> 2)), AW'(a)); tick();
    end
    for (int a = 0; a < DEPTH; a++) begin
      drive(1'b0, AW'(a), '0, AW'(DEPTH - 1 - a));
      check("R1 rw fill", rw_rdata, exp_word(AW'(a)));
      check("R1 sp fill", sp_rw_rdata, exp_word(AW'(a)));
      check("R4 ro fill", ro_rdata, exp_word(AW'(DEPTH - 1 - a)));
    end

    // R2: we low with new data has no effect
    drive(1'b0, 4'd6, ~model[6], 4'd6); tick();
    check("R2 idle", rw_rdata, exp_word(4'd6));
    check("R2 idle ro", ro_rdata, exp_word(4'd6));

    // R3: writes blocked in reset, contents kept
    @(negedge clk); rst = 1'b1;
    drive(1'b1, 4'd5, ~model[5], 4'd5); tick();
    check("R3 in reset", rw_rdata, exp_word(4'd5));
    @(negedge clk); rst = 1'b0; we = 1'b0; #1;
    check("R3 after reset", rw_rdata, exp_word(4'd5));
    check("R3 after reset ro", ro_rdata, exp_word(4'd5));

    // R6: collision, old before edge, new after
    drive(1'b1, 4'd9, ~model[9], 4'd9);
    check("R6 old", ro_rdata, exp_word(4'd9));
    tick();
    check("R6 new", ro_rdata, exp_word(4'd9));
    check("R5 mirror", ro_rdata, rw_rdata);

    // R8: address change alone moves outputs, no clock edge
    @(negedge clk); we = 1'b0;
    for (int a = 0; a < DEPTH; a++) begin
      ro_addr = AW'(a); waddr = AW'(DEPTH - 1 - a); #1;
      check("R8 ro async", ro_rdata, exp_word(AW'(a)));
      check("R8 rw async", rw_rdata, exp_word(AW'(DEPTH - 1 - a)));
    end

    // Random mix (R1, R2, R4, R5, R7)
    for (int i = 0; i < 400; i++) begin
      logic [AW-1:0] a, ra;
      a  = AW'($urandom_range(DEPTH - 1));
      ra = ($urandom_range(3) == 0) ? a : AW'($urandom_range(DEPTH - 1));
      drive(($urandom_range(2) != 0), a, W'($urandom), ra);
      check("R1 rand rw", rw_rdata, exp_word(a));
      check("R4 rand ro", ro_rdata, exp_word(ra));
      check("R7 rand sp", sp_ro_rdata, '0);
      check("R1 rand sp rw", sp_rw_rdata, exp_word(a));
      if (ra == a) check("R5 rand mirror", ro_rdata, rw_rdata);
      tick();
      check("R1 post rw", rw_rdata, exp_word(a));
      check("R4 post ro", ro_rdata, exp_word(ra));
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule